// File: doc/BRIEF.md
# Chained Character Convert Sequencer

This block runs the character translation operations of a 36-bit machine whose words are six 6-bit characters. After a start command it steps through one character per memory access. The character value is added to the current table base to form the read address. The word that comes back holds two things. Its top six bits are the replacement for the character. Its low fifteen bits are the base of the table used for the following character. Chaining tables this way lets a program build a translation state machine in memory.

Three modes exist. The first two replace characters in place: one in the multiplier-quotient word, working left to right, and one in the accumulator word, working right to left. The third leaves the characters alone and adds each fetched word to the accumulator. After each step the word rotates by one character, so the character just handled goes back in at the far end. With a count of six the word ends in its original orientation. With a larger count the walk wraps around and visits characters a second time. When the sequence ends, the block reports the new register values on write-enable outputs. It can also report the last table base for index register 1.

Top module: `cvt_seq`

## Requirements
- R1: During reset and directly after it, `busy_o`, `done_o`, `mem_req_o`, `ac_we_o`, `mq_we_o` and `xr1_we_o` are all low.
- R2: Each character gets exactly one read. The read address is the current table base plus the 6-bit character value, modulo 2^15. The next read is not issued until `mem_rvalid_i` has returned the previous word.
- R3: The low 15 bits of each fetched word become the table base for the next character. The `base_i` value given at start is used only for the first character.
- R4: With `mode_i` equal to 0 or 3, the characters of `mq_i` are taken from bits 35:30 onward, from left to right. Each one is replaced by bits 35:30 of its fetched word, and then the word rotates left by six bits. At the end, `mq_we_o` is asserted with the result on `mq_o`, and `ac_we_o` stays low.
- R5: With `mode_i` equal to 1, the characters of `ac_i` are taken from bits 5:0 onward, from right to left. Each one is replaced, and then the word rotates right by six bits. In the first replacement only, bit 5 is ORed with `q_i`. At the end, `ac_we_o` is asserted with the result on `ac_o`, and `mq_we_o` stays low.
- R6: With `mode_i` equal to 2, the characters of `mq_i` are visited from left to right without being changed, and `mq_i` rotates left six bits per step. Each fetched 36-bit word is added to the accumulator modulo 2^36. At the end, both `ac_we_o` and `mq_we_o` are asserted.
- R7: A count above six keeps walking the rotated word. The seventh character handled is therefore the first character as already processed.
- R8: `done_o` is a single-cycle pulse in the cycle after the last read data is accepted. `busy_o` is low in that cycle, and the write enables are valid only while `done_o` is high.
- R9: When `xr1_sel_i` was high at start, `xr1_we_o` pulses with `done_o` and `xr1_o` holds the final table base. Otherwise `xr1_we_o` stays low.
- R10: A start with a count of zero raises `done_o` in the next cycle. No read is issued and no write enable is asserted.
- R11: A start while `busy_o` is high is ignored, and the running operation completes with its own parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled while idle |
| mode_i | input | 2 | 0/3 MQ replace, 1 accumulator replace, 2 add |
| base_i | input | 15 | First table base |
| count_i | input | 8 | Number of characters to process |
| xr1_sel_i | input | 1 | Report final base for index register 1 |
| ac_i | input | 36 | Accumulator value at start |
| mq_i | input | 36 | MQ value at start |
| q_i | input | 1 | Previous Q bit |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 15 | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 36 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| ac_o | output | 36 | New accumulator value |
| mq_o | output | 36 | New MQ value |
| xr1_o | output | 15 | Final table base |
| ac_we_o | output | 1 | Accumulator write enable |
| mq_we_o | output | 1 | MQ write enable |
| xr1_we_o | output | 1 | Index register 1 write enable |

## Verification
A start sampled at one rising edge raises `mem_req_o` for the next cycle. Read data is accepted at the earliest one cycle after that. `done_o`, the write enables and the result values appear in the cycle after the edge that accepts the last word. A zero count produces `done_o` one cycle after the start. The bench samples every output at the falling edge. The memory responder compares each request address at the falling edge where the request is seen, then drives valid data one or more falling edges later, so the data lands in the wait state. The monitor pops an expected result at each falling edge where `done_o` is high, so a result that is early, late, missing or extra is reported.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    CV_MQ_REPL = 2'd0,
    CV_AC_REPL = 2'd1,
    CV_MQ_ADD  = 2'd2,
    CV_RSVD    = 2'd3
  } cvt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } cvt_state_e;
endpackage

// File: rtl/cvt_char_unit.sv
// Picks the active character and forms the rotated, possibly replaced word.
module cvt_char_unit #(
  parameter int WORD_W = 36,
  parameter int CH_W   = 6
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CH_W-1:0]   repl_i,
  input  logic              q_or_i,
  input  logic              right_i,
  input  logic              add_i,
  output logic [CH_W-1:0]   char_o,
  output logic [WORD_W-1:0] word_o
);
  logic [CH_W-1:0] repl_mod;
  logic [CH_W-1:0] new_char;

  always_comb begin
    char_o   = right_i ? word_i[CH_W-1:0] : word_i[WORD_W-1 -: CH_W];
    repl_mod = repl_i | {q_or_i, {(CH_W-1){1'b0}}};
    new_char = add_i ? char_o : repl_mod;
    word_o   = right_i ? {new_char, word_i[WORD_W-1:CH_W]}
                       : {word_i[WORD_W-CH_W-1:0], new_char};
  end
endmodule

// File: rtl/cvt_addr_gen.sv
// Table base plus character index, wrapping in the address space.
module cvt_addr_gen #(
  parameter int ADDR_W = 15,
  parameter int CH_W   = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CH_W-1:0]   char_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = base_i + ADDR_W'(char_i);
endmodule

// File: rtl/cvt_seq.sv
module cvt_seq
  import cvt_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CH_W   = 6,
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              xr1_sel_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic [WORD_W-1:0] mq_i,
  input  logic              q_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] ac_o,
  output logic [WORD_W-1:0] mq_o,
  output logic [ADDR_W-1:0] xr1_o,
  output logic              ac_we_o,
  output logic              mq_we_o,
  output logic              xr1_we_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cvt_state_e        state_q, state_d;
  logic              right_q, right_d, add_q, add_d, xsel_q, xsel_d;
  logic              first_q, first_d, qb_q, qb_d;
  logic [WORD_W-1:0] word_q, word_d, acc_q, acc_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d, acwe_q, acwe_d, mqwe_q, mqwe_d;
  logic              xwe_q, xwe_d;

  logic [CH_W-1:0]   cur_char;
  logic [WORD_W-1:0] word_step;

  cvt_char_unit #(.WORD_W(WORD_W), .CH_W(CH_W)) u_char (
    .word_i  (word_q),
    .repl_i  (mem_rdata_i[WORD_W-1 -: CH_W]),
    .q_or_i  (qb_q & first_q & right_q),
    .right_i (right_q),
    .add_i   (add_q),
    .char_o  (cur_char),
    .word_o  (word_step)
  );

  cvt_addr_gen #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_addr (
    .base_i (base_q),
    .char_i (cur_char),
    .addr_o (mem_addr_o)
  );

  always_comb begin
    state_d = state_q;
    right_d = right_q;
    add_d   = add_q;
    xsel_d  = xsel_q;
    first_d = first_q;
    qb_d    = qb_q;
    word_d  = word_q;
    acc_d   = acc_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    acwe_d  = 1'b0;
    mqwe_d  = 1'b0;
    xwe_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (count_i == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_REQ;
            right_d = (cvt_mode_e'(mode_i) == CV_AC_REPL);
            add_d   = (cvt_mode_e'(mode_i) == CV_MQ_ADD);
            xsel_d  = xr1_sel_i;
            word_d  = (cvt_mode_e'(mode_i) == CV_AC_REPL) ? ac_i : mq_i;
            acc_d   = ac_i;
            base_d  = base_i;
            cnt_d   = count_i;
            first_d = 1'b1;
            qb_d    = q_i;
          end
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid_i) begin
          word_d  = word_step;
          base_d  = mem_rdata_i[ADDR_W-1:0];
          cnt_d   = cnt_q - CNT_ONE;
          first_d = 1'b0;
          if (add_q) acc_d = acc_q + mem_rdata_i;
          if (cnt_q == CNT_ONE) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            acwe_d  = right_q | add_q;
            mqwe_d  = ~right_q;
            xwe_d   = xsel_q;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      right_q <= 1'b0;
      add_q   <= 1'b0;
      xsel_q  <= 1'b0;
      first_q <= 1'b0;
      qb_q    <= 1'b0;
      word_q  <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      acwe_q  <= 1'b0;
      mqwe_q  <= 1'b0;
      xwe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      right_q <= right_d;
      add_q   <= add_d;
      xsel_q  <= xsel_d;
      first_q <= first_d;
      qb_q    <= qb_d;
      word_q  <= word_d;
      acc_q   <= acc_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      acwe_q  <= acwe_d;
      mqwe_q  <= mqwe_d;
      xwe_q   <= xwe_d;
    end
  end

  assign mem_req_o = (state_q == ST_REQ);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign ac_o      = right_q ? word_q : acc_q;
  assign mq_o      = word_q;
  assign xr1_o     = base_q;
  assign ac_we_o   = acwe_q;
  assign mq_we_o   = mqwe_q;
  assign xr1_we_o  = xwe_q;

  // R2: a request lasts one cycle, then the engine waits for data
  p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req_o |=> !mem_req_o);

  // R2: nothing advances while the read is outstanding
  p_hold_wait_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_WAIT && !mem_rvalid_i) |=>
      ($stable(word_q) && $stable(base_q) && $stable(cnt_q)));

  // R8: the completion pulse comes with the engine idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o);

  // R10: zero count finishes next cycle without writes
  p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_IDLE && start_i && count_i == '0) |=>
      (done_o && !busy_o && !ac_we_o && !mq_we_o && !xr1_we_o));

  // R11: a start while busy leaves the captured mode alone
  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && start_i) |=> ($stable(right_q) && $stable(add_q)));

  // R9: index write only together with completion
  always_comb begin
    if (rst_n_s) begin
      p_xr1_with_done_r9: assert (!xr1_we_o || done_o);
    end
  end
endmodule

// File: tb/cvt_seq_tb.sv
`timescale 1ns/1ps
module cvt_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  mode_i;
  logic [14:0] base_i;
  logic [7:0]  count_i;
  logic        xr1_sel_i;
  logic [35:0] ac_i, mq_i;
  logic        q_i;
  logic        mem_req_o;
  logic [14:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [35:0] mem_rdata_i;
  logic        busy_o, done_o;
  logic [35:0] ac_o, mq_o;
  logic [14:0] xr1_o;
  logic        ac_we_o, mq_we_o, xr1_we_o;

  always #2.5 clk = ~clk;

  cvt_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .base_i(base_i), .count_i(count_i), .xr1_sel_i(xr1_sel_i),
    .ac_i(ac_i), .mq_i(mq_i), .q_i(q_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .ac_o(ac_o), .mq_o(mq_o),
    .xr1_o(xr1_o), .ac_we_o(ac_we_o), .mq_we_o(mq_we_o),
    .xr1_we_o(xr1_we_o)
  );

  typedef struct packed {
    logic [35:0] ac;
    logic [35:0] mq;
    logic [14:0] xr;
    logic        acwe;
    logic        mqwe;
    logic        xwe;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [14:0] addr_q[$];
  int          checks = 0;
  int          errors = 0;
  int          lat = 0;
  bit          live = 1'b0;
  bit          ended = 1'b0;

  function automatic logic [35:0] mem_word(input logic [14:0] a);
    logic [14:0] nxt;
    nxt = a * 15'd37 + 15'd129;
    return {a[5:0] ^ 6'h2d, a ^ 15'h1234, nxt};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: model the requirements, push expectations, issue the start
  task automatic run_op(input logic [1:0] mode, input logic [14:0] base,
                        input logic [7:0] count, input logic xsel,
                        input logic [35:0] ac, input logic [35:0] mq,
                        input logic q, input string tag);
    logic [35:0] w, acc;
    logic [14:0] b;
    exp_t        e;
    w   = (mode == 2'd1) ? ac : mq;
    acc = ac;
    b   = base;
    for (int i = 0; i < int'(count); i++) begin
      logic [5:0]  ch, rep;
      logic [14:0] a;
      logic [35:0] d;
      ch = (mode == 2'd1) ? w[5:0] : w[35:30];
      a  = b + {9'd0, ch};
      addr_q.push_back(a);
      d   = mem_word(a);
      rep = d[35:30];
      if (mode == 2'd1 && i == 0 && q) rep[5] = 1'b1;
      if (mode == 2'd2) begin
        acc = acc + d;
        w   = {w[29:0], w[35:30]};
      end else if (mode == 2'd1) begin
        w = {rep, w[35:6]};
      end else begin
        w = {w[29:0], rep};
      end
      b = d[14:0];
    end
    e.ac   = (mode == 2'd1) ? w : acc;
    e.mq   = w;
    e.xr   = b;
    e.acwe = (count != 0) && (mode == 2'd1 || mode == 2'd2);
    e.mqwe = (count != 0) && (mode != 2'd1);
    e.xwe  = (count != 0) && xsel;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    start_i = 1'b1; mode_i = mode; base_i = base; count_i = count;
    xr1_sel_i = xsel; ac_i = ac; mq_i = mq; q_i = q;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  // memory responder: compares each address, answers after a delay
  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '1;
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      mem_rdata_i  = '1;
      if (mem_req_o) begin
        logic [14:0] a;
        a = mem_addr_o;
        if (addr_q.size() == 0) begin
          chk(1'b0, "R2/R10 unexpected read", 64'(a), 64'h0);
        end else begin
          logic [14:0] ea;
          ea = addr_q.pop_front();
          chk(a == ea, "R2/R3 read address", 64'(a), 64'(ea));
        end
        repeat (lat) @(negedge clk);
        @(negedge clk);
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_word(a);
      end
    end
  end

  // monitor: pop and compare at each completion
  always @(negedge clk) begin
    if (live && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8/R11 extra done", 64'(done_o), 64'h0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(busy_o == 1'b0, {t, " R8 busy at done"}, 64'(busy_o), 64'h0);
        chk({ac_we_o, mq_we_o, xr1_we_o} == {e.acwe, e.mqwe, e.xwe},
            {t, " write enables"}, 64'({ac_we_o, mq_we_o, xr1_we_o}),
            64'({e.acwe, e.mqwe, e.xwe}));
        if (e.acwe) chk(ac_o == e.ac, {t, " ac_o"}, 64'(ac_o), 64'(e.ac));
        if (e.mqwe) chk(mq_o == e.mq, {t, " mq_o"}, 64'(mq_o), 64'(e.mq));
        if (e.xwe)  chk(xr1_o == e.xr, {t, " xr1_o"}, 64'(xr1_o), 64'(e.xr));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; base_i = '0; count_i = '0;
    xr1_sel_i = 1'b0; ac_i = '0; mq_i = '0; q_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, mem_req_o, ac_we_o, mq_we_o, xr1_we_o} == 6'b0,
        "R1 reset outputs",
        64'({busy_o, done_o, mem_req_o, ac_we_o, mq_we_o, xr1_we_o}), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, done_o, mem_req_o, ac_we_o, mq_we_o, xr1_we_o} == 6'b0,
        "R1 after release",
        64'({busy_o, done_o, mem_req_o, ac_we_o, mq_we_o, xr1_we_o}), 64'h0);
    live = 1'b1;

    lat = 0;
    run_op(2'd0, 15'h0100, 8'd6, 1'b0, 36'h123456789, 36'h0A1B2C3D4, 1'b0, "R4 mq replace");
    run_op(2'd1, 15'h2040, 8'd6, 1'b0, 36'h0FEDCBA98, 36'h555555555, 1'b1, "R5 ac replace q=1");
    lat = 2;
    run_op(2'd1, 15'h7FF0, 8'd3, 1'b0, 36'h000000041, 36'h0, 1'b0, "R5 ac replace q=0");
    run_op(2'd2, 15'h0300, 8'd4, 1'b0, 36'hF00000000, 36'h8899AABBC, 1'b0, "R6 add mode");
    run_op(2'd2, 15'h7FC5, 8'd6, 1'b1, 36'hFFFFFFFF0, 36'hFFFFFFFFF, 1'b0, "R6 R9 add wrap");
    lat = 3;
    run_op(2'd0, 15'h0040, 8'd14, 1'b1, 36'h0, 36'h3C3C3C3C3, 1'b0, "R7 R9 long count");
    run_op(2'd3, 15'h1111, 8'd2, 1'b0, 36'h0, 36'hABCDEF012, 1'b0, "R4 mode3");
    lat = 1;
    run_op(2'd0, 15'h0500, 8'd0, 1'b1, 36'h1, 36'h2, 1'b1, "R10 zero count");
    run_op(2'd1, 15'h0500, 8'd1, 1'b0, 36'h00000003F, 36'h0, 1'b1, "R5 single char");

    // R11: a second start while busy must not change the running operation
    fork
      run_op(2'd0, 15'h0600, 8'd5, 1'b0, 36'h0, 36'h111111111, 1'b0, "R11 busy start");
      begin
        repeat (4) @(negedge clk);
        start_i = 1'b1; mode_i = 2'd2; count_i = 8'd1; base_i = 15'h0;
        @(negedge clk);
        start_i = 1'b0;
      end
    join

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all completions seen", 64'(exp_q.size()), 64'h0);
    chk(addr_q.size() == 0, "R2 all reads seen", 64'(addr_q.size()), 64'h0);
    finish_run();
  end
endmodule